// File: doc/BRIEF.md
# Configuration Image CRC-8 Validator

This block checks a stored image of 16-bit configuration words while it is being read. It fetches the words one at a time over a request/acknowledge read port and runs a byte-wide CRC-8 over them. When it reaches the final word it compares the inverted CRC with the check byte held in that word. It also reports the revision byte, which sits in the same word.

The image can be one of two sizes, and the size is not known in advance. The block therefore probes. It first validates the image as a short image of `SHORT_WORDS` words. If that check fails, it reads the image again from word zero as a 220-word image and checks it once more. A single pulse on `done` marks the end of the job. `result_ok` says whether either size passed. `long_sel` says which size the result belongs to, and `revision` gives the low byte of the final word of that size. A start request is taken only while the block is idle.

Top module: `cfgimg_crc_check`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `busy`, `done`, `rd_req` and `result_ok` low.
- R2: The CRC is an 8-bit reflected CRC. Its polynomial is x^8+x^7+x^6+x^4+x^2+1 (right-shifting constant 0xAB) and its register is preset to 0xFF. A single byte update from register value 0x00 gives the table value: 0x01 gives 0xF7, 0x02 gives 0xB9, 0x80 gives 0xAB and 0xFF gives 0x9F. Every byte value 0..255 is processed to the same result as that table.
- R3: Every word except the final one adds its bits [7:0] to the CRC first and its bits [15:8] second.
- R4: The final word adds only its bits [7:0]. The CRC is then XORed with 0xFF, and the image passes when this value equals bits [15:8] of the final word.
- R5: `revision` shows bits [7:0] of the final word of the size that is reported.
- R6: A job first reads words 0 to `SHORT_WORDS`-1 in increasing order, one word per step. If that check passes, the job ends with `result_ok`=1 and `long_sel`=0, and no further word is read.
- R7: If the short check fails, words 0 to 219 are read in order and checked. A pass then ends the job with `result_ok`=1 and `long_sel`=1.
- R8: If both checks fail, the job ends with `result_ok`=0 and `long_sel`=1.
- R9: `rd_req` stays high, and `rd_addr` stays unchanged, until a cycle with `rd_ack` high. `rd_data` is taken in that cycle. `rd_req` is high only while `busy` is high.
- R10: `start` is ignored while `busy` is high: the read order and the result are unchanged. `busy` rises only in the cycle after `start` was seen.
- R11: `done` is high for exactly one cycle, with `busy` low. `result_ok`, `long_sel` and `revision` hold their values until the next job ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a validation job (taken when idle) |
| rd_req | output | 1 | Word read request |
| rd_addr | output | ADDR_W | Word address of the request |
| rd_ack | input | 1 | Read data valid; completes the request |
| rd_data | input | 16 | Word returned by the image store |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse at the end of a job |
| result_ok | output | 1 | An image size passed its check |
| long_sel | output | 1 | 0: short size reported, 1: 220-word size |
| revision | output | 8 | Bits [7:0] of the final word of the reported size |

## Verification
Two events can fall in the same cycle: a new `start` request and a read acknowledge in the middle of a job. The bench raises `start` on the very clock edge at which `rd_ack` completes a word. It then checks two things. First, the address stream must continue from the next word and must not restart at zero. Second, the single `done` pulse must carry the result that the bench model computes for one uninterrupted job. Acknowledge latency varies from word to word, so the same collision also lands on different sequencer states.

// File: rtl/cfgcrc_pkg.sv
// Package: shared constants and sequencer state type for the image validator.
// Assumes a reflected CRC-8 with 16-bit image words.
package cfgcrc_pkg;
    localparam int          BYTE_W         = 8;
    localparam int          WORD_W         = 16;
    localparam logic [7:0]  CRC_PRESET     = 8'hFF;
    localparam logic [7:0]  CRC_POLY_REFL  = 8'hAB;
    localparam logic [7:0]  CRC_XOROUT     = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_LO,
        ST_HI,
        ST_CHECK
    } seq_state_t;
endpackage

// File: rtl/cfgcrc_byte_step.sv
// Module: one-byte update of a reflected CRC-8, fully unrolled over 8 bits.
// Assumes the polynomial is given in right-shifting (reflected) form.
module cfgcrc_byte_step
    import cfgcrc_pkg::*;
#(
    parameter logic [7:0] POLY = CRC_POLY_REFL
) (
    input  logic [BYTE_W-1:0] crc_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic [BYTE_W-1:0] crc_out
);
    // Shift eight times, folding in the polynomial when the low bit is set.
    always_comb begin
        logic [BYTE_W-1:0] acc;
        acc = crc_in ^ data_in;
        for (int b = 0; b < BYTE_W; b++) begin
            acc = acc[0] ? ((acc >> 1) ^ POLY) : (acc >> 1);
        end
        crc_out = acc;
    end
endmodule

// File: rtl/cfgcrc_datapath.sv
// Module: word latch, CRC register, check comparison and revision capture.
// Assumes at most one of feed_lo/feed_hi is high in a cycle, and that
// crc_init takes priority over feeding.
module cfgcrc_datapath
    import cfgcrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [WORD_W-1:0] word_in,
    input  logic              crc_init,
    input  logic              feed_lo,
    input  logic              feed_hi,
    input  logic              rev_take,
    output logic              match,
    output logic [BYTE_W-1:0] revision
);
    logic [WORD_W-1:0] word_q;
    logic [BYTE_W-1:0] crc_q;
    logic [BYTE_W-1:0] byte_sel;
    logic [BYTE_W-1:0] crc_nxt;

    // Select the byte of the latched word that is fed in this cycle.
    assign byte_sel = feed_hi ? word_q[WORD_W-1:BYTE_W] : word_q[BYTE_W-1:0];

    cfgcrc_byte_step #(.POLY(CRC_POLY_REFL)) u_step (
        .crc_in  (crc_q),
        .data_in (byte_sel),
        .crc_out (crc_nxt)
    );

    // Compare the inverted CRC with the check byte of the latched word.
    assign match = ((crc_q ^ CRC_XOROUT) == word_q[WORD_W-1:BYTE_W]);

    // Hold the fetched word, the running CRC and the reported revision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            crc_q    <= CRC_PRESET;
            revision <= '0;
        end else begin
            if (cap) word_q <= word_in;
            if (crc_init) crc_q <= CRC_PRESET;
            else if (feed_lo || feed_hi) crc_q <= crc_nxt;
            if (rev_take) revision <= word_q[BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/cfgcrc_seq.sv
// Module: job sequencer. It walks the word addresses, drives the read
// handshake, orders the byte feeds and runs the short-then-long size probe.
// Assumes the read store keeps rd_data valid in the cycle rd_ack is high.
module cfgcrc_seq
    import cfgcrc_pkg::*;
#(
    parameter int SHORT_WORDS = 64,
    parameter int LONG_WORDS  = 220,
    parameter int ADDR_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_ack,
    input  logic              match,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              done,
    output logic              result_ok,
    output logic              long_sel,
    output logic              cap,
    output logic              crc_init,
    output logic              feed_lo,
    output logic              feed_hi,
    output logic              rev_take
);
    localparam logic [ADDR_W-1:0] SHORT_LAST = ADDR_W'(SHORT_WORDS - 1);
    localparam logic [ADDR_W-1:0] LONG_LAST  = ADDR_W'(LONG_WORDS - 1);

    seq_state_t st;
    logic       long_pass;
    logic       at_last;
    logic       finish;

    // Decode the final word of the size now being probed.
    assign at_last  = (rd_addr == (long_pass ? LONG_LAST : SHORT_LAST));
    assign finish   = (st == ST_CHECK) && (match || long_pass);

    // Control strobes for the datapath.
    assign cap      = (st == ST_READ) && rd_ack;
    assign feed_lo  = (st == ST_LO);
    assign feed_hi  = (st == ST_HI);
    assign rev_take = finish;
    assign crc_init = ((st == ST_IDLE) && start)
                    || ((st == ST_CHECK) && !match && !long_pass);

    // State, address and result registers of the job.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            long_pass <= 1'b0;
            rd_addr   <= '0;
            rd_req    <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b0;
            result_ok <= 1'b0;
            long_sel  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        busy      <= 1'b1;
                        long_pass <= 1'b0;
                        rd_addr   <= '0;
                        rd_req    <= 1'b1;
                        st        <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (rd_ack) begin
                        rd_req <= 1'b0;
                        st     <= ST_LO;
                    end
                end
                ST_LO: begin
                    st <= at_last ? ST_CHECK : ST_HI;
                end
                ST_HI: begin
                    rd_addr <= rd_addr + 1'b1;
                    rd_req  <= 1'b1;
                    st      <= ST_READ;
                end
                ST_CHECK: begin
                    if (finish) begin
                        done      <= 1'b1;
                        busy      <= 1'b0;
                        result_ok <= match;
                        long_sel  <= long_pass;
                        st        <= ST_IDLE;
                    end else begin
                        long_pass <= 1'b1;
                        rd_addr   <= '0;
                        rd_req    <= 1'b1;
                        st        <= ST_READ;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfgimg_crc_check.sv
// Module: top of the configuration image CRC-8 validator. It joins the
// sequencer and the datapath. Assumes LONG_WORDS > SHORT_WORDS >= 2.
module cfgimg_crc_check
    import cfgcrc_pkg::*;
#(
    parameter int SHORT_WORDS = 64,
    parameter int LONG_WORDS  = 220,
    localparam int ADDR_W     = $clog2(LONG_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [15:0]       rd_data,
    output logic              busy,
    output logic              done,
    output logic              result_ok,
    output logic              long_sel,
    output logic [7:0]        revision
);
    logic cap, crc_init, feed_lo, feed_hi, rev_take, match;

    cfgcrc_seq #(
        .SHORT_WORDS (SHORT_WORDS),
        .LONG_WORDS  (LONG_WORDS),
        .ADDR_W      (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rd_ack    (rd_ack),
        .match     (match),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .done      (done),
        .result_ok (result_ok),
        .long_sel  (long_sel),
        .cap       (cap),
        .crc_init  (crc_init),
        .feed_lo   (feed_lo),
        .feed_hi   (feed_hi),
        .rev_take  (rev_take)
    );

    cfgcrc_datapath u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .word_in  (rd_data),
        .crc_init (crc_init),
        .feed_lo  (feed_lo),
        .feed_hi  (feed_hi),
        .rev_take (rev_take),
        .match    (match),
        .revision (revision)
    );
endmodule

// File: rtl/cfgcrc_check_sva.sv
// Module: protocol and result properties of the validator, bound to its top.
module cfgcrc_check_sva #(
    parameter int LONG_WORDS = 220,
    parameter int ADDR_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic              busy,
    input logic              done,
    input logic              result_ok,
    input logic              long_sel
);
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !rd_req && !result_ok));

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

    assert_addr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (int'(rd_addr) < LONG_WORDS));

    assert_fail_long_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !result_ok) |-> long_sel);

    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind cfgimg_crc_check cfgcrc_check_sva #(
    .LONG_WORDS (LONG_WORDS),
    .ADDR_W     (ADDR_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_ack    (rd_ack),
    .busy      (busy),
    .done      (done),
    .result_ok (result_ok),
    .long_sel  (long_sel)
);

// File: tb/cfgimg_crc_check_bench.sv
`timescale 1ns/1ps
module cfgimg_crc_check_bench;
    localparam int SHORTW = 64;
    localparam int LONGW  = 220;
    localparam int AW     = $clog2(LONGW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [15:0]   rd_data = '0;
    logic          busy, done, result_ok, long_sel;
    logic [7:0]    revision;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] mem [0:LONGW-1];
    int exp_addr[$];
    int lat_seed = 0;
    int done_seen = 0;

    always #2 clk = ~clk;

    cfgimg_crc_check #(.SHORT_WORDS(SHORTW), .LONG_WORDS(LONGW)) u_cfgimg_crc_check (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy), .done(done),
        .result_ok(result_ok), .long_sel(long_sel), .revision(revision)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference CRC step: bitwise long division with the reflected polynomial.
    function automatic logic [7:0] ref_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 8'hAB) : (r >> 1);
        return r;
    endfunction

    // Reference check value of an n-word image held in mem.
    function automatic logic [7:0] ref_crc(input int n);
        logic [7:0] c;
        c = 8'hFF;
        for (int w = 0; w < n - 1; w++) begin
            c = ref_step(c, mem[w][7:0]);
            c = ref_step(c, mem[w][15:8]);
        end
        c = ref_step(c, mem[n-1][7:0]);
        return c ^ 8'hFF;
    endfunction

    // Read store: answers requests after a varying latency, driven at negedge.
    initial begin
        int waitc;
        int lat;
        waitc = 0;
        lat = 0;
        forever begin
            @(negedge clk);
            if (rd_ack) rd_ack = 1'b0;
            else if (rd_req) begin
                if (waitc >= lat) begin
                    // R6 R7: order of word addresses against the model queue
                    if (exp_addr.size() == 0) chk(1'b0, "R6/R7 extra read", int'(rd_addr), -1);
                    else begin
                        int e;
                        e = exp_addr.pop_front();
                        chk(int'(rd_addr) == e, "R6/R7 address order", int'(rd_addr), e);
                    end
                    rd_data = mem[rd_addr];
                    rd_ack  = 1'b1;
                    waitc   = 0;
                    lat_seed = lat_seed + 1;
                    lat = lat_seed % 3;
                end else waitc++;
            end
        end
    end

    // Count done pulses on every clock for the model comparison.
    initial forever begin
        @(negedge clk);
        if (done) done_seen++;
    end

    // Run one job, with an optional start pulse injected mid-job (R10).
    task automatic run_job(input string tag, input int inject_at);
        bit sok, lok, exp_ok, exp_long;
        logic [7:0] exp_rev;
        int cyc;
        int d0;
        sok = (ref_crc(SHORTW) == mem[SHORTW-1][15:8]);
        lok = (ref_crc(LONGW) == mem[LONGW-1][15:8]);
        exp_addr.delete();
        for (int a = 0; a < SHORTW; a++) exp_addr.push_back(a);
        if (!sok) for (int a = 0; a < LONGW; a++) exp_addr.push_back(a);
        exp_ok   = sok || lok;
        exp_long = !sok;
        exp_rev  = sok ? mem[SHORTW-1][7:0] : mem[LONGW-1][7:0];
        d0 = done_seen;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            // R10: raise start on an edge where an acknowledge lands
            if (inject_at > 0 && cyc >= inject_at && rd_ack) begin
                start = 1'b1;
                inject_at = 0;
            end else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done == 1'b1, {tag, " R11 done seen"}, done, 1);
        chk(result_ok == exp_ok, {tag, " R4/R6/R7/R8 result_ok"}, result_ok, exp_ok);
        chk(long_sel == exp_long, {tag, " R6/R7/R8 long_sel"}, long_sel, exp_long);
        chk(revision == exp_rev, {tag, " R5 revision"}, revision, exp_rev);
        chk(exp_addr.size() == 0, {tag, " R6/R7 reads left"}, exp_addr.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R11 pulse width"}, done, 0);
        chk(busy == 1'b0, {tag, " R10 no restart"}, busy, 0);
        repeat (3) @(negedge clk);
        chk(result_ok == exp_ok && long_sel == exp_long && revision == exp_rev,
            {tag, " R11 outputs held"}, {result_ok, long_sel, revision}, {exp_ok, exp_long, exp_rev});
        chk(done_seen - d0 == 1, {tag, " R11 single done"}, done_seen - d0, 1);
    endtask

    task automatic fill_pattern(input int seed);
        for (int i = 0; i < LONGW; i++) mem[i] = 16'((i * 40503 + seed * 7919) ^ (i << 9));
    endtask

    initial begin
        // Watchdog: a hung run counts as a failure and still reports.
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R2: reference step against known table entries
        chk(ref_step(8'h00, 8'h01) == 8'hF7, "R2 table 0x01", ref_step(8'h00, 8'h01), 8'hF7);
        chk(ref_step(8'h00, 8'h02) == 8'hB9, "R2 table 0x02", ref_step(8'h00, 8'h02), 8'hB9);
        chk(ref_step(8'h00, 8'h80) == 8'hAB, "R2 table 0x80", ref_step(8'h00, 8'h80), 8'hAB);
        chk(ref_step(8'h00, 8'hFF) == 8'h9F, "R2 table 0xFF", ref_step(8'h00, 8'hFF), 8'h9F);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !rd_req && !result_ok, "R1 reset state",
            {busy, done, rd_req, result_ok}, 0);

        // Short image valid (R3, R4, R6)
        fill_pattern(1);
        mem[SHORTW-1][15:8] = ref_crc(SHORTW);
        run_job("short-pass", 0);

        // Short fails, long valid (R7)
        fill_pattern(2);
        mem[SHORTW-1][15:8] = ref_crc(SHORTW) ^ 8'h01;
        mem[LONGW-1][15:8]  = ref_crc(LONGW);
        run_job("long-pass", 0);

        // Both fail (R8)
        fill_pattern(3);
        mem[SHORTW-1][15:8] = ref_crc(SHORTW) ^ 8'h40;
        mem[LONGW-1][15:8]  = ref_crc(LONGW) ^ 8'h02;
        run_job("both-fail", 0);

        // Every byte value 0..255 in the long image (R2)
        for (int i = 0; i < LONGW; i++) mem[i] = {8'((2 * i + 1) % 256), 8'((2 * i) % 256)};
        mem[SHORTW-1][15:8] = ref_crc(SHORTW) ^ 8'h80;
        mem[LONGW-1][15:8]  = ref_crc(LONGW);
        run_job("all-bytes R2", 0);

        // Byte order: image valid in word order, same image with bytes swapped fails (R3)
        fill_pattern(5);
        mem[SHORTW-1][15:8] = ref_crc(SHORTW);
        run_job("order-ok R3", 0);
        for (int i = 0; i < SHORTW - 1; i++) mem[i] = {mem[i][7:0], mem[i][15:8]};
        mem[0] = 16'h12A5;
        mem[LONGW-1][15:8] = ref_crc(LONGW) ^ 8'h10;
        run_job("order-swap R3", 0);

        // Start during a busy job, coinciding with an acknowledge (R10)
        fill_pattern(6);
        mem[SHORTW-1][15:8] = ref_crc(SHORTW) ^ 8'h04;
        mem[LONGW-1][15:8]  = ref_crc(LONGW);
        run_job("start-collide R10", 37);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule